// File: doc/BRIEF.md
# Delayed Read Restart and Flush Controller

This block sits between the host-side read-data FIFO and the target engine of a bus interface. It serves a delayed read that an outside bus master has started against this device. While the read is pending, the block watches every write that completes on the bus. When a write lands inside the pending read's word window, the data the host is preparing may be stale. The block then asks the host to fetch the read again and throws away FIFO entries until the host marks the end of the stale batch.

The host stages read data into a FIFO. Each entry carries a 3-bit tag. After the block has raised a restart, it pops and drops entries up to and including the first terminator (a last-data entry or an abort entry). It then goes back to accepting data. Accepted entries go to the target engine, decoded into separate flags. The block also reports, once per pending period, that earlier writes have drained and the read is now being serviced. A data phase whose byte enables do not cover the whole word is marked for disconnect.

Top module: `dread_flush_ctrl`

## Requirements
- R1: After reset, `dv_vld` and `rsp_vld` are low and the block is idle. In the idle state a FIFO entry with tag 100 is not popped.
- R2: A `rd_arm` pulse in the idle state captures `rd_base`, `rd_len` and `rd_be` and makes the read pending. A `rd_arm` pulse while a read is pending or flushing is ignored and leaves the captured window unchanged.
- R3: While a read is pending or flushing, a write (`wr_vld`) whose word address lies in the inclusive range `rd_base` to `rd_base + rd_len - 1` gives `rsp_vld` with `rsp_tag` = 4'h8 on the next cycle. Writes outside that range, and any write while idle, give no response.
- R4: In a cycle with an overlapping write, `fifo_pop` is low whatever the FIFO offers.
- R5: After a restart, every popped entry is dropped without asserting `dv_vld`, up to and including the first terminator. Terminators are tag 001, 110 or 111. Later entries are delivered again.
- R6: A restart raised while already flushing sends tag 4'h8 again but needs no extra terminator. One terminator ends the flush.
- R7: Spare tags 000 and 010 are popped (`fifo_pop` high with `fifo_vld`) and produce no output, in every state including idle.
- R8: In the pending state, a popped entry gives `dv_vld` on the next cycle, with `dv_data` equal to the entry data. Tag 100 is plain data. Tag 101 sets `dv_perr`. Tag 110 sets `dv_last`. Tag 111 sets `dv_last` and `dv_perr`. Tag 001 sets `dv_abort`. Tag 011 sets `dv_retry`. A last or abort entry ends the read and returns the block to idle.
- R9: In the pending state, with `wr_drained` high, the block sends `rsp_tag` = 4'h9 exactly once. A restart clears this, so the tag is sent once more after the flush completes.
- R10: The byte enables `rd_be` (active high, bit i = byte i) are captured at arm. Every delivered data entry (tags 1xx) has `dv_disc` high when the captured enables are not 4'b1111, and low when they are.
- R11: When an overlapping write and the drained condition occur in the same pending cycle, only the restart response (4'h8) is sent.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| rd_arm | input | 1 | Start of a delayed read (one-cycle pulse) |
| rd_base | input | AW | First word address of the read |
| rd_len | input | LW | Read length in words |
| rd_be | input | 4 | Byte enables of the read, active high |
| wr_vld | input | 1 | A bus write has completed this cycle |
| wr_addr | input | AW | Word address of that write |
| wr_drained | input | 1 | All earlier writes have finished |
| fifo_vld | input | 1 | The read-data FIFO presents an entry |
| fifo_tag | input | 3 | Tag of the presented entry |
| fifo_data | input | DW | Data of the presented entry |
| fifo_pop | output | 1 | The presented entry is consumed this cycle |
| rsp_vld | output | 1 | A response to the host is valid |
| rsp_tag | output | 4 | Response code: 8 = restart, 9 = now serviced |
| dv_vld | output | 1 | Entry delivered to the target engine |
| dv_data | output | DW | Delivered data |
| dv_last | output | 1 | Delivered entry ends the burst |
| dv_perr | output | 1 | Delivered entry carries a parity error |
| dv_abort | output | 1 | Host signalled target abort |
| dv_retry | output | 1 | Host asked for a fast retry |
| dv_disc | output | 1 | Data phase must end in a disconnect |

## Verification
The bench builds the block with AW = 32, LW = 8 and DW = 32. With these values a window fits well clear of address zero, so writes one word below the base and one word past the end can be sent to probe both edges of the inclusive range. An 8-bit length allows windows of one and two words. This puts the single-word case, where base and end coincide, within reach. The full 32-bit data path lets each delivered entry carry a distinct word, so any dropped or duplicated entry during a flush is caught by the scoreboard.

// File: rtl/dfc_pkg.sv
package dfc_pkg;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_PEND  = 2'd1,
    ST_FLUSH = 2'd2
  } dfc_state_e;

  localparam logic [2:0] TAG_SPARE_A   = 3'b000;
  localparam logic [2:0] TAG_ABORT     = 3'b001;
  localparam logic [2:0] TAG_SPARE_B   = 3'b010;
  localparam logic [2:0] TAG_FRETRY    = 3'b011;

  localparam logic [3:0] RSP_RESTART   = 4'h8;
  localparam logic [3:0] RSP_SERVICED  = 4'h9;

  localparam logic [3:0] BE_FULL       = 4'b1111;

  // Entries that carry nothing and are dropped in any state.
  function automatic logic tag_is_spare(input logic [2:0] t);
    return (t == TAG_SPARE_A) || (t == TAG_SPARE_B);
  endfunction

  // Entries that close a batch: last-data (with or without parity) or abort.
  function automatic logic tag_is_term(input logic [2:0] t);
    return (t == TAG_ABORT) || (t[2:1] == 2'b11);
  endfunction

  function automatic logic tag_is_data(input logic [2:0] t);
    return t[2];
  endfunction

  function automatic logic tag_is_last(input logic [2:0] t);
    return t[2] && t[1];
  endfunction

  function automatic logic tag_has_perr(input logic [2:0] t);
    return t[2] && t[0];
  endfunction

endpackage

// File: rtl/dfc_window.sv
module dfc_window #(
  parameter int AW = 32,
  parameter int LW = 8
) (
  input  logic [AW-1:0] base,
  input  logic [LW-1:0] len,
  input  logic [AW-1:0] addr,
  output logic          hit
);
  localparam int XW = (AW > LW) ? AW + 1 : LW + 1;

  logic [XW-1:0] offs;
  logic [XW-1:0] len_x;
  logic          at_or_above;

  always_comb begin
    at_or_above = (addr >= base);
    offs        = XW'(addr) - XW'(base);
    len_x       = XW'(len);
    hit         = at_or_above && (offs < len_x);
  end
endmodule

// File: rtl/dfc_capture.sv
module dfc_capture #(
  parameter int AW = 32,
  parameter int LW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [AW-1:0] base_in,
  input  logic [LW-1:0] len_in,
  input  logic [3:0]    be_in,
  output logic [AW-1:0] base_q,
  output logic [LW-1:0] len_q,
  output logic [3:0]    be_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      base_q <= '0;
      len_q  <= '0;
      be_q   <= '0;
    end else if (load) begin
      base_q <= base_in;
      len_q  <= len_in;
      be_q   <= be_in;
    end
  end
endmodule

// File: rtl/dfc_seq.sv
module dfc_seq
  import dfc_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        rd_arm,
  input  logic        wr_hit,
  input  logic        wr_drained,
  input  logic        fifo_vld,
  input  logic [2:0]  fifo_tag,
  output dfc_state_e  state,
  output logic        arm_take,
  output logic        fifo_pop,
  output logic        deliver,
  output logic        restart,
  output logic        serviced,
  output logic        rsp_vld,
  output logic [3:0]  rsp_tag
);
  dfc_state_e nxt;
  logic       active;
  logic       spare;
  logic       take;
  logic       term;
  logic       svc_sent;

  always_comb begin
    active   = (state != ST_IDLE);
    spare    = tag_is_spare(fifo_tag);
    term     = tag_is_term(fifo_tag);
    restart  = active && wr_hit;
    arm_take = rd_arm && (state == ST_IDLE);
    fifo_pop = fifo_vld && !restart && (spare || active);
    take     = fifo_pop && !spare;
    deliver  = take && (state == ST_PEND);
    serviced = (state == ST_PEND) && wr_drained && !svc_sent && !restart;
  end

  always_comb begin
    nxt = state;
    unique case (state)
      ST_IDLE:  if (arm_take) nxt = ST_PEND;
      ST_PEND: begin
        if (restart)              nxt = ST_FLUSH;
        else if (deliver && term) nxt = ST_IDLE;
      end
      ST_FLUSH: if (take && term) nxt = ST_PEND;
      default:  nxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= ST_IDLE;
      svc_sent <= 1'b0;
      rsp_vld  <= 1'b0;
      rsp_tag  <= '0;
    end else begin
      state <= nxt;
      if (arm_take || restart) svc_sent <= 1'b0;
      else if (serviced)       svc_sent <= 1'b1;
      rsp_vld <= restart || serviced;
      rsp_tag <= restart ? RSP_RESTART : RSP_SERVICED;
    end
  end

  // R3
  restart_rsp_chk: assert property (@(posedge clk) disable iff (!rst_n)
    restart |=> (rsp_vld && rsp_tag == RSP_RESTART));

  // R9
  serviced_once_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_vld && rsp_tag == RSP_SERVICED) |=> !(rsp_vld && rsp_tag == RSP_SERVICED));

  // R8
  term_ends_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (deliver && term) |=> (state == ST_IDLE));

  // R7
  idle_pop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_IDLE && fifo_pop) |-> tag_is_spare(fifo_tag));

  // R5
  flush_exit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(state) == ST_FLUSH && state == ST_PEND) |-> $past(term && fifo_pop));
endmodule

// File: rtl/dfc_deliver.sv
module dfc_deliver
  import dfc_pkg::*;
#(
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          deliver,
  input  logic [2:0]    tag,
  input  logic [DW-1:0] data,
  input  logic [3:0]    be,
  output logic          dv_vld,
  output logic [DW-1:0] dv_data,
  output logic          dv_last,
  output logic          dv_perr,
  output logic          dv_abort,
  output logic          dv_retry,
  output logic          dv_disc
);
  logic partial;

  always_comb partial = (be != BE_FULL);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dv_vld   <= 1'b0;
      dv_data  <= '0;
      dv_last  <= 1'b0;
      dv_perr  <= 1'b0;
      dv_abort <= 1'b0;
      dv_retry <= 1'b0;
      dv_disc  <= 1'b0;
    end else begin
      dv_vld   <= deliver;
      if (deliver) dv_data <= data;
      dv_last  <= deliver && tag_is_last(tag);
      dv_perr  <= deliver && tag_has_perr(tag);
      dv_abort <= deliver && (tag == TAG_ABORT);
      dv_retry <= deliver && (tag == TAG_FRETRY);
      dv_disc  <= deliver && tag_is_data(tag) && partial;
    end
  end

  // R10
  disc_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dv_disc |-> dv_vld);

  // R8
  flag_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({dv_last, dv_abort, dv_retry}));
endmodule

// File: rtl/dread_flush_ctrl.sv
module dread_flush_ctrl
  import dfc_pkg::*;
#(
  parameter int AW = 32,
  parameter int LW = 8,
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          rd_arm,
  input  logic [AW-1:0] rd_base,
  input  logic [LW-1:0] rd_len,
  input  logic [3:0]    rd_be,
  input  logic          wr_vld,
  input  logic [AW-1:0] wr_addr,
  input  logic          wr_drained,
  input  logic          fifo_vld,
  input  logic [2:0]    fifo_tag,
  input  logic [DW-1:0] fifo_data,
  output logic          fifo_pop,
  output logic          rsp_vld,
  output logic [3:0]    rsp_tag,
  output logic          dv_vld,
  output logic [DW-1:0] dv_data,
  output logic          dv_last,
  output logic          dv_perr,
  output logic          dv_abort,
  output logic          dv_retry,
  output logic          dv_disc
);
  logic [AW-1:0] win_base;
  logic [LW-1:0] win_len;
  logic [3:0]    win_be;
  logic          in_win;
  logic          wr_hit;
  logic          arm_take;
  logic          deliver;
  logic          restart;
  logic          serviced;
  dfc_state_e    state;

  always_comb wr_hit = wr_vld && in_win;

  dfc_capture #(.AW(AW), .LW(LW)) u_cap (
    .clk     (clk),
    .rst_n   (rst_n),
    .load    (arm_take),
    .base_in (rd_base),
    .len_in  (rd_len),
    .be_in   (rd_be),
    .base_q  (win_base),
    .len_q   (win_len),
    .be_q    (win_be)
  );

  dfc_window #(.AW(AW), .LW(LW)) u_win (
    .base (win_base),
    .len  (win_len),
    .addr (wr_addr),
    .hit  (in_win)
  );

  dfc_seq u_seq (
    .clk        (clk),
    .rst_n      (rst_n),
    .rd_arm     (rd_arm),
    .wr_hit     (wr_hit),
    .wr_drained (wr_drained),
    .fifo_vld   (fifo_vld),
    .fifo_tag   (fifo_tag),
    .state      (state),
    .arm_take   (arm_take),
    .fifo_pop   (fifo_pop),
    .deliver    (deliver),
    .restart    (restart),
    .serviced   (serviced),
    .rsp_vld    (rsp_vld),
    .rsp_tag    (rsp_tag)
  );

  dfc_deliver #(.DW(DW)) u_dlv (
    .clk      (clk),
    .rst_n    (rst_n),
    .deliver  (deliver),
    .tag      (fifo_tag),
    .data     (fifo_data),
    .be       (win_be),
    .dv_vld   (dv_vld),
    .dv_data  (dv_data),
    .dv_last  (dv_last),
    .dv_perr  (dv_perr),
    .dv_abort (dv_abort),
    .dv_retry (dv_retry),
    .dv_disc  (dv_disc)
  );

  // R5
  flush_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_FLUSH) |=> !dv_vld);

  // R4
  restart_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_vld && in_win && state != ST_IDLE) |-> !fifo_pop);

  // R11
  restart_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (restart && wr_drained) |=> (rsp_tag == RSP_RESTART));

  // R2
  arm_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_arm && state != ST_IDLE) |=> $stable(win_base) && $stable(win_len));

  // R1
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_IDLE && !serviced) |=> !dv_vld || $past(deliver));
endmodule

// File: tb/dread_flush_ctrl_bench.sv
module dread_flush_ctrl_bench;
  localparam int AW = 32;
  localparam int LW = 8;
  localparam int DW = 32;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          rd_arm = 1'b0;
  logic [AW-1:0] rd_base = '0;
  logic [LW-1:0] rd_len = '0;
  logic [3:0]    rd_be = '0;
  logic          wr_vld = 1'b0;
  logic [AW-1:0] wr_addr = '0;
  logic          wr_drained = 1'b0;
  logic          fifo_vld = 1'b0;
  logic [2:0]    fifo_tag = '0;
  logic [DW-1:0] fifo_data = '0;
  logic          fifo_pop;
  logic          rsp_vld;
  logic [3:0]    rsp_tag;
  logic          dv_vld;
  logic [DW-1:0] dv_data;
  logic          dv_last, dv_perr, dv_abort, dv_retry, dv_disc;

  int n_chk = 0;
  int n_fail = 0;
  bit mon_on = 1'b0;
  logic [3:0] cur_be = 4'hF;

  logic [3:0]    rsp_q[$];
  logic [DW+4:0] dv_q[$];

  always #2 clk = ~clk;

  dread_flush_ctrl #(.AW(AW), .LW(LW), .DW(DW)) u_dread_flush_ctrl (
    .clk(clk), .rst_n(rst_n), .rd_arm(rd_arm), .rd_base(rd_base), .rd_len(rd_len),
    .rd_be(rd_be), .wr_vld(wr_vld), .wr_addr(wr_addr), .wr_drained(wr_drained),
    .fifo_vld(fifo_vld), .fifo_tag(fifo_tag), .fifo_data(fifo_data), .fifo_pop(fifo_pop),
    .rsp_vld(rsp_vld), .rsp_tag(rsp_tag), .dv_vld(dv_vld), .dv_data(dv_data),
    .dv_last(dv_last), .dv_perr(dv_perr), .dv_abort(dv_abort), .dv_retry(dv_retry),
    .dv_disc(dv_disc)
  );

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic cyc();
    @(posedge clk);
    @(negedge clk);
  endtask

  // Monitor: compare every produced item with the scoreboard queues.
  always @(negedge clk) begin
    if (mon_on) begin
      if (rsp_vld) begin
        if (rsp_q.size() == 0) chk(1'b0, "R3/R9 unexpected response", 64'(rsp_tag), 64'hF);
        else begin
          logic [3:0] e;
          e = rsp_q.pop_front();
          chk(rsp_tag == e, "R3/R9/R11 response tag", 64'(rsp_tag), 64'(e));
        end
      end
      if (dv_vld) begin
        logic [DW+4:0] a;
        a = {dv_last, dv_perr, dv_abort, dv_retry, dv_disc, dv_data};
        if (dv_q.size() == 0) chk(1'b0, "R5/R8 unexpected delivery", 64'(a), 64'h0);
        else begin
          logic [DW+4:0] e;
          e = dv_q.pop_front();
          chk(a == e, "R8/R10 delivered entry", 64'(a), 64'(e));
        end
      end
    end
  end

  // Present one FIFO entry for one cycle; expect pop and optional delivery.
  task automatic put(input logic [2:0] tag, input logic [DW-1:0] d, input bit exp_pop,
                     input bit exp_dv, input string req);
    fifo_vld  = 1'b1;
    fifo_tag  = tag;
    fifo_data = d;
    #1;
    chk(fifo_pop == exp_pop, req, 64'(fifo_pop), 64'(exp_pop));
    if (exp_dv)
      dv_q.push_back({tag[2] & tag[1], tag[2] & tag[0], tag == 3'b001, tag == 3'b011,
                      tag[2] & (cur_be != 4'hF), d});
    cyc();
    fifo_vld = 1'b0;
  endtask

  task automatic wr(input logic [AW-1:0] a, input logic [3:0] exp_rsp);
    wr_vld  = 1'b1;
    wr_addr = a;
    if (exp_rsp != 4'h0) rsp_q.push_back(exp_rsp);
    cyc();
    wr_vld = 1'b0;
  endtask

  task automatic arm(input logic [AW-1:0] b, input logic [LW-1:0] l, input logic [3:0] be, input bit take);
    rd_arm  = 1'b1;
    rd_base = b;
    rd_len  = l;
    rd_be   = be;
    if (take) cur_be = be;
    cyc();
    rd_arm = 1'b0;
  endtask

  initial begin : wdog
    repeat (5000) @(posedge clk);
    chk(1'b0, "watchdog", 64'h0, 64'h1);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin : main
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(dv_vld == 1'b0, "R1 dv_vld in reset", 64'(dv_vld), 64'h0);
    chk(rsp_vld == 1'b0, "R1 rsp_vld in reset", 64'(rsp_vld), 64'h0);
    rst_n = 1'b1;
    cyc();
    mon_on = 1'b1;
    chk(dv_vld == 1'b0 && rsp_vld == 1'b0, "R1 outputs after reset", 64'({dv_vld, rsp_vld}), 64'h0);

    // Idle: spares popped, data held, writes ignored
    put(3'b000, 32'h11, 1'b1, 1'b0, "R7 spare 000 popped in idle");
    put(3'b010, 32'h12, 1'b1, 1'b0, "R7 spare 010 popped in idle");
    put(3'b100, 32'h13, 1'b0, 1'b0, "R1 data held in idle");
    wr(32'h0000_0100, 4'h0);

    // Read A: window 0x100..0x103, full enables
    arm(32'h0000_0100, 8'd4, 4'hF, 1'b1);
    wr(32'h0000_00FF, 4'h0);              // R3 below window
    wr(32'h0000_0104, 4'h0);              // R3 past window
    wr(32'h0000_0103, 4'h8);              // R3 top edge hits
    put(3'b100, 32'hA0, 1'b1, 1'b0, "R5 stale data dropped");
    put(3'b010, 32'hA1, 1'b1, 1'b0, "R7 spare popped while flushing");
    put(3'b101, 32'hA2, 1'b1, 1'b0, "R5 stale perr data dropped");
    // R4 overlap with entry present: hold, and R6 repeated restart
    wr_vld = 1'b1; wr_addr = 32'h0000_0100; fifo_vld = 1'b1; fifo_tag = 3'b110; fifo_data = 32'hA3;
    rsp_q.push_back(4'h8);
    #1;
    chk(fifo_pop == 1'b0, "R4 no pop on overlap cycle", 64'(fifo_pop), 64'h0);
    cyc();
    wr_vld = 1'b0; fifo_vld = 1'b0;
    put(3'b110, 32'hA3, 1'b1, 1'b0, "R6 single terminator ends flush");
    wr_drained = 1'b1;
    rsp_q.push_back(4'h9);                // R9 serviced response
    cyc();
    cyc();                                // R9 no repeat
    put(3'b100, 32'hB0, 1'b1, 1'b1, "R5 fresh data delivered");
    put(3'b101, 32'hB1, 1'b1, 1'b1, "R8 perr data");
    put(3'b011, 32'hB2, 1'b1, 1'b1, "R8 fast retry");
    put(3'b100, 32'hB3, 1'b1, 1'b1, "R10 full enables no disc");
    put(3'b111, 32'hB4, 1'b1, 1'b1, "R8 last with perr ends read");
    put(3'b100, 32'hB5, 1'b0, 1'b0, "R8 idle after last");
    wr(32'h0000_0101, 4'h0);              // R3 idle write ignored

    // Read B: single word 0x200, partial enables
    arm(32'h0000_0200, 8'd1, 4'b0011, 1'b1);
    wr(32'h0000_0200, 4'h8);              // R11 drained high too: only restart
    put(3'b100, 32'hC0, 1'b1, 1'b0, "R5 stale dropped");
    put(3'b001, 32'hC1, 1'b1, 1'b0, "R5 abort terminates flush");
    rsp_q.push_back(4'h9);                // R9 resent after flush
    cyc();
    put(3'b100, 32'hC2, 1'b1, 1'b1, "R10 partial enables disconnect");
    put(3'b110, 32'hC3, 1'b1, 1'b1, "R10 last data disconnect");
    wr_drained = 1'b0;

    // Read C: window 0x300..0x301, arm while busy ignored
    arm(32'h0000_0300, 8'd2, 4'hF, 1'b1);
    arm(32'h0000_0400, 8'd8, 4'b0001, 1'b0);   // R2 ignored
    wr(32'h0000_0400, 4'h0);              // R2 old window kept
    wr(32'h0000_0302, 4'h0);              // R3 one past end
    wr(32'h0000_0301, 4'h8);              // R3 hit
    put(3'b110, 32'hD0, 1'b1, 1'b0, "R5 terminator consumed in flush");
    put(3'b100, 32'hD1, 1'b1, 1'b1, "R2 enables from first arm");
    put(3'b001, 32'hD2, 1'b1, 1'b1, "R8 abort ends read");
    put(3'b101, 32'hD3, 1'b0, 1'b0, "R8 idle after abort");
    cyc();
    cyc();

    chk(rsp_q.size() == 0, "R3/R9 all responses seen", 64'(rsp_q.size()), 64'h0);
    chk(dv_q.size() == 0, "R8 all deliveries seen", 64'(dv_q.size()), 64'h0);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule